// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block is a memory-mapped peripheral with three 8-bit parallel ports (A, B and C), reached from a host through a small synchronous register bus. Port C is treated as two independent 4-bit halves, an upper and a lower nibble. A single write-only control location accepts one of two kinds of command, told apart by the top bit of the written byte. One kind reconfigures every port at once. The other sets or clears one bit of port C.

Each port half has one direction bit, where 1 means input. The output latch of every bit is always presented on its output pin, and each output-enable pin is the inverse of its direction bit, so the pads can use external tri-state buffers. Input pins pass through a synchronizer chain before they can be read. The handshake mode fields are decoded, held and brought out on pins, but the ports themselves always behave as plain I/O.

The host bus has no valid/ready handshake and applies no back-pressure. Every strobe seen on a rising edge while chip select is high is taken in that cycle, and read data is returned combinationally in the same cycle as the read strobe.

Top module: `tri_port_pio`

## Requirements
- R1: Address 2'b00 selects port A, 2'b01 selects port B, 2'b10 selects port C, and 2'b11 selects the control location.
- R2: A control write with bit 7 = 1 is a configuration word. Its direction bits are: bit 4 for port A, bit 3 for the upper nibble of C, bit 1 for port B and bit 0 for the lower nibble of C, with 1 meaning input. From the next cycle, every output-enable bit equals the inverse of the direction bit of its port or nibble.
- R3: A configuration word clears every output latch (`pa_o`, `pb_o` and `pc_o` all read 0x00 in the cycle after the write).
- R4: In a configuration word, bits 6:5 give the group A mode on `mode_a`: 00 gives 0, 01 gives 1, and 10 or 11 give 2. Bit 2 gives `mode_b`. The ports move data in modes 1 and 2 exactly as they do in mode 0.
- R5: A control write with bit 7 = 0 is a port C bit command. Bits 3:1 are the bit index and bit 0 is the new value. Only that bit of `pc_o` changes, and directions and modes stay as they were.
- R6: While reset is held, all ports are inputs (all output enables 0), all output latches are 0, and both mode outputs are 0.
- R7: A read of a port or nibble set to input returns its pins as they were SYNC_STAGES clock edges earlier. A read of one set to output returns its latch. For port C, each nibble follows its own direction.
- R8: A read of the control location returns 0x00, and `rdata` is 0x00 whenever no read is selected.
- R9: When `cs` is low, read and write strobes have no effect on any latch, direction or mode.
- R10: A write to a port address loads its latch at the next rising edge, whatever the direction. The latch is shown on the port's output pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not reading |
| mode_a | output | 2 | Stored group A mode (0, 1, 2) |
| mode_b | output | 1 | Stored port B mode |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The assertions assume that the address and write data are stable while a strobe is high, and that `rd` and `wr` are never high in the same cycle. They make no assumption about when the pins change, because the pins pass through the synchronizer. The bench's driver tasks raise one strobe at a time for exactly one cycle. They change the bus and the pins just after a rising edge, and before reading an input port they wait longer than the synchronizer depth.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_BASIC   = 2'd0,
    MODE_STROBED = 2'd1,
    MODE_BIDIR   = 2'd2
  } grp_mode_e;

  typedef struct packed {
    grp_mode_e mode_a;
    logic      mode_b;
    logic      a_in;
    logic      cu_in;
    logic      b_in;
    logic      cl_in;
  } port_cfg_t;

  localparam port_cfg_t CFG_RESET = '{
    mode_a: MODE_BASIC, mode_b: 1'b0,
    a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1
  };
endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [PORT_W-1:0] wdata,
  output port_cfg_t         cfg,
  output logic              cfg_load,
  output logic [PORT_W-1:0] bsr_mask,
  output logic              bsr_val
);
  port_cfg_t cfg_q;
  port_cfg_t cfg_d;
  logic      is_cfg_word;

  assign is_cfg_word = wdata[PORT_W-1];
  assign cfg_load    = ctrl_we && is_cfg_word;
  assign bsr_val     = wdata[0];
  assign bsr_mask    = (ctrl_we && !is_cfg_word) ?
                       (PORT_W'(1) << wdata[IDX_W:1]) : '0;

  always_comb begin
    cfg_d        = cfg_q;
    cfg_d.mode_a = wdata[6] ? MODE_BIDIR : (wdata[5] ? MODE_STROBED : MODE_BASIC);
    cfg_d.mode_b = wdata[2];
    cfg_d.a_in   = wdata[4];
    cfg_d.cu_in  = wdata[3];
    cfg_d.b_in   = wdata[1];
    cfg_d.cl_in  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_load) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  assert_cfg_dirs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[7]) |=> (cfg.a_in == $past(wdata[4]) && cfg.cu_in == $past(wdata[3])
                               && cfg.b_in == $past(wdata[1]) && cfg.cl_in == $past(wdata[0])));

  assert_mode2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[7] && wdata[6]) |=> (cfg.mode_a == MODE_BIDIR));

  assert_bsr_keeps_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdata[7]) |=> $stable(cfg));
endmodule

// File: rtl/pio_port_slice.sv
module pio_port_slice #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_in,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] bit_en,
  input  logic         bit_val,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] out_q;
  logic [W-1:0] sync_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else        sync_q[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   out_q <= '0;
    else if (clr) out_q <= '0;
    else if (we)  out_q <= wdata;
    else begin
      for (int b = 0; b < W; b++) begin
        if (bit_en[b]) out_q[b] <= bit_val;
      end
    end
  end

  assign out_o = out_q;
  assign oe_o  = {W{~dir_in}};
  assign rd_o  = dir_in ? sync_q[SYNC_STAGES-1] : out_q;

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_o == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || we || (|bit_en)) |=> $stable(out_o));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (out_o == $past(wdata)));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [1:0] mode_a,
  output logic       mode_b,
  input  logic [7:0] pa_i,
  output logic [7:0] pa_o,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_i,
  output logic [7:0] pb_o,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_i,
  output logic [7:0] pc_o,
  output logic [7:0] pc_oe
);
  port_cfg_t         cfg;
  logic              cfg_load;
  logic [PORT_W-1:0] bsr_mask;
  logic              bsr_val;
  logic              wr_hit, rd_hit;
  logic              we_a, we_b, we_c, we_ctrl;
  logic [PORT_W-1:0] rd_a, rd_b;
  logic [NIB_W-1:0]  rd_cl, rd_cu;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(addr);
  assign wr_hit  = cs && wr;
  assign rd_hit  = cs && rd;
  assign we_a    = wr_hit && (sel == SEL_A);
  assign we_b    = wr_hit && (sel == SEL_B);
  assign we_c    = wr_hit && (sel == SEL_C);
  assign we_ctrl = wr_hit && (sel == SEL_CTRL);

  pio_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (we_ctrl),
    .wdata    (wdata),
    .cfg      (cfg),
    .cfg_load (cfg_load),
    .bsr_mask (bsr_mask),
    .bsr_val  (bsr_val)
  );

  pio_port_slice #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
    .clk(clk), .rst_n(rst_n), .dir_in(cfg.a_in), .clr(cfg_load), .we(we_a),
    .wdata(wdata), .bit_en('0), .bit_val(1'b0), .pin_i(pa_i),
    .out_o(pa_o), .oe_o(pa_oe), .rd_o(rd_a)
  );

  pio_port_slice #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
    .clk(clk), .rst_n(rst_n), .dir_in(cfg.b_in), .clr(cfg_load), .we(we_b),
    .wdata(wdata), .bit_en('0), .bit_val(1'b0), .pin_i(pb_i),
    .out_o(pb_o), .oe_o(pb_oe), .rd_o(rd_b)
  );

  pio_port_slice #(.W(NIB_W), .SYNC_STAGES(SYNC_STAGES)) u_port_cl (
    .clk(clk), .rst_n(rst_n), .dir_in(cfg.cl_in), .clr(cfg_load), .we(we_c),
    .wdata(wdata[NIB_W-1:0]), .bit_en(bsr_mask[NIB_W-1:0]), .bit_val(bsr_val),
    .pin_i(pc_i[NIB_W-1:0]), .out_o(pc_o[NIB_W-1:0]), .oe_o(pc_oe[NIB_W-1:0]),
    .rd_o(rd_cl)
  );

  pio_port_slice #(.W(NIB_W), .SYNC_STAGES(SYNC_STAGES)) u_port_cu (
    .clk(clk), .rst_n(rst_n), .dir_in(cfg.cu_in), .clr(cfg_load), .we(we_c),
    .wdata(wdata[PORT_W-1:NIB_W]), .bit_en(bsr_mask[PORT_W-1:NIB_W]), .bit_val(bsr_val),
    .pin_i(pc_i[PORT_W-1:NIB_W]), .out_o(pc_o[PORT_W-1:NIB_W]), .oe_o(pc_oe[PORT_W-1:NIB_W]),
    .rd_o(rd_cu)
  );

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      unique case (sel)
        SEL_A:    rdata = rd_a;
        SEL_B:    rdata = rd_b;
        SEL_C:    rdata = {rd_cu, rd_cl};
        SEL_CTRL: rdata = '0;
        default:  rdata = '0;
      endcase
    end
  end

  assign mode_a = cfg.mode_a;
  assign mode_b = cfg.mode_b;

  assert_ctrl_unreadable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit || addr == 2'b11) |-> (rdata == 8'h00));

  assert_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable({pa_o, pb_o, pc_o, pa_oe, pb_oe, pc_oe}) && $stable({mode_a, mode_b})));

  assert_cfg_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'b11 && wdata[7]) |=> (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00));

  assert_bsr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'b11 && !wdata[7]) |=>
      ($countones(pc_o ^ $past(pc_o)) <= 1 && pc_o[$past(wdata[3:1])] == $past(wdata[0])
       && $stable(pa_o) && $stable(pb_o)));

  assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'b11 && wdata[7]) |=>
      (pa_oe == {8{~$past(wdata[4])}} && pb_oe == {8{~$past(wdata[1])}}
       && pc_oe == {{4{~$past(wdata[3])}}, {4{~$past(wdata[0])}}}));
endmodule

// File: tb/tri_port_pio_test.sv
`timescale 1ns/1ps
module tri_port_pio_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] mode_a;
  logic       mode_b;
  logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #4 clk = ~clk;

  tri_port_pio uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mode_a(mode_a), .mode_b(mode_b),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(posedge clk); #1;
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    cs = 1'b1; rd = 1'b1; addr = a;
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #2;
  endtask

  // monitor: pops expected read data when a selected read is on the bus
  initial begin
    forever begin
      @(negedge clk);
      if (cs && rd) begin
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R1: unexpected read, actual %02h expected none", rdata);
        end else begin
          chk(req_q.pop_front(), rdata, exp_q.pop_front());
        end
      end else if (rst_n) begin
        if (rdata !== 8'h00) chk("R8 idle rdata", rdata, 8'h00);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    pa_i = 8'h3C; pb_i = 8'hA5; pc_i = 8'h96;
    repeat (3) @(posedge clk);
    #2;
    // R6 reset state
    chk("R6 pa_oe", pa_oe, 8'h00);
    chk("R6 pc_oe", pc_oe, 8'h00);
    chk("R6 pb_o", pb_o, 8'h00);
    chk("R6 modes", {5'd0, mode_b, mode_a}, 8'h00);
    @(posedge clk); #1; rst_n = 1'b1;
    settle();
    // R7/R1 inputs read back pins
    bus_read(2'b00, 8'h3C, "R1 R7 port A pins");
    bus_read(2'b01, 8'hA5, "R1 R7 port B pins");
    bus_read(2'b10, 8'h96, "R1 R7 port C pins");
    bus_read(2'b11, 8'h00, "R8 control read");
    // R2 all outputs
    bus_write(2'b11, 8'h80, 1'b1);
    #2;
    chk("R2 pa_oe all out", pa_oe, 8'hFF);
    chk("R2 pb_oe all out", pb_oe, 8'hFF);
    chk("R2 pc_oe all out", pc_oe, 8'hFF);
    chk("R4 mode_a 0", {6'd0, mode_a}, 8'h00);
    // R10 port writes
    bus_write(2'b00, 8'h55, 1'b1);
    bus_write(2'b01, 8'hAA, 1'b1);
    bus_write(2'b10, 8'h5A, 1'b1);
    #2;
    chk("R10 pa_o", pa_o, 8'h55);
    chk("R10 pb_o", pb_o, 8'hAA);
    chk("R10 pc_o", pc_o, 8'h5A);
    bus_read(2'b00, 8'h55, "R7 port A latch");
    bus_read(2'b10, 8'h5A, "R7 port C latch");
    // R9 deselected writes ignored
    bus_write(2'b00, 8'hFF, 1'b0);
    bus_write(2'b11, 8'h9B, 1'b0);
    #2;
    chk("R9 pa_o unchanged", pa_o, 8'h55);
    chk("R9 pa_oe unchanged", pa_oe, 8'hFF);
    // R5 bit set/reset on port C
    bus_write(2'b11, 8'h0F, 1'b1);
    #2;
    chk("R5 set bit7", pc_o, 8'hDA);
    bus_write(2'b11, 8'h02, 1'b1);
    #2;
    chk("R5 clear bit1", pc_o, 8'hD8);
    chk("R5 dirs kept", pc_oe, 8'hFF);
    chk("R5 port A kept", pa_o, 8'h55);
    // R2/R3 mixed config clears latches
    bus_write(2'b11, 8'h8A, 1'b1);
    #2;
    chk("R3 pa_o cleared", pa_o, 8'h00);
    chk("R3 pb_o cleared", pb_o, 8'h00);
    chk("R3 pc_o cleared", pc_o, 8'h00);
    chk("R2 pb_oe input", pb_oe, 8'h00);
    chk("R2 pc_oe split", pc_oe, 8'h0F);
    bus_read(2'b10, 8'h90, "R7 port C split read");
    bus_write(2'b10, 8'h0F, 1'b1);
    bus_read(2'b10, 8'h9F, "R7 R10 port C split after write");
    bus_read(2'b01, 8'hA5, "R7 port B input");
    // R4 modes
    bus_write(2'b11, 8'hE4, 1'b1);
    #2;
    chk("R4 mode_a 2", {6'd0, mode_a}, 8'h02);
    chk("R4 mode_b 1", {7'd0, mode_b}, 8'h01);
    bus_write(2'b00, 8'h33, 1'b1);
    bus_read(2'b00, 8'h33, "R4 data path in mode 2");
    bus_write(2'b11, 8'hA0, 1'b1);
    #2;
    chk("R4 mode_a 1", {6'd0, mode_a}, 8'h01);
    chk("R4 mode_b 0", {7'd0, mode_b}, 8'h00);
    // R7 pin change seen after sync
    bus_write(2'b11, 8'h9B, 1'b1);
    @(posedge clk); #1; pa_i = 8'h11;
    settle();
    chk("R2 pa_oe input", pa_oe, 8'h00);
    bus_read(2'b00, 8'h11, "R7 new pin value");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) chk("R1 pending reads", 8'(exp_q.size()), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule